// File: doc/BRIEF.md
# Serial-Bus Control Register Slave

This block is a target on a two-wire serial bus (I2C signalling). It lets a bus master reach a bank of 256 byte-wide control registers that the rest of the chip reads in parallel. The two bus lines are brought into the system clock domain through two-flop synchronizers. Every bus event is then found by edge detection, so the system clock must run well above the bus rate: at least twenty times faster for 400 kHz traffic.

A master writes by sending the device address with a write flag, then one register index, then any number of data bytes. A master reads by sending the device address with a read flag. Data then comes back from an internal index that an earlier transaction left behind. That index steps after every byte in either direction and keeps its value between transactions. Register 0x00 is the control register. Bit 0 asks for a soft reset of the whole bank, and bit 1 holds the power-down request for the rest of the chip.

Top module: `i2c_reg_slave`

## Requirements
- R1: The first byte after START carries the 7-bit device address (default 1000000b) in its upper bits and the direction in its LSB, where 1 means read and 0 means write. On a match the slave pulls SDA low in the ninth clock. On a mismatch SDA stays released until the next START or STOP, and no register changes.
- R2: In a write, the second byte sets the register index and every later byte is stored at the index. The slave acknowledges each of these bytes.
- R3: The index advances by one after every stored byte and wraps from 0xFF to 0x00.
- R4: A read returns bytes from the index left by earlier transactions. The index advances by one after each byte sent and keeps its value after STOP.
- R5: Bytes travel MSB first in both directions.
- R6: When the master does not acknowledge a read byte, the slave releases SDA and keeps it released until the next START or STOP.
- R7: A START seen at any point, including inside a byte, abandons the current transfer and begins a new address match.
- R8: Writing a byte with bit 0 set to register 0x00 returns every register k to its default value k. For that write, `soft_rst` is high for exactly one system clock. The index is not affected and still advances.
- R9: `soft_pwrdn` follows bit 1 of register 0x00. The other registers keep their contents while it is set.
- R10: After `rst`, every register k holds k, the index is 0x00, SDA is released, and both `soft_rst` and `soft_pwrdn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Asynchronous reset, active high |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low (open drain) |
| soft_rst | output | 1 | One-clock pulse when a soft reset is carried out |
| soft_pwrdn | output | 1 | Power-down request for the rest of the chip |
| regs_o | output | 2048 | All registers side by side, register k at bits 8k+7..8k |

## Verification
On every cycle the assertions check four things: SDA is driven only in acknowledge or transmit phases, a START always lands in a fresh address phase, each stored byte advances the index by exactly one, and the soft-reset pulse lasts one clock and leaves the bank at its defaults. Some behaviours show only at the ports across whole transactions, so only the bench's scenarios can demonstrate them. These are the index carried from one transaction to the next, the wrap at 0xFF, silence after a wrong address or a master NACK, recovery from a START inside a byte, and a full write-then-read sweep of registers 0x01 to 0xFF.

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'b1000000,
  parameter int unsigned NREG = 256,
  parameter int unsigned CTRL_IDX = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe,
  output logic                 soft_rst,
  output logic                 soft_pwrdn,
  output logic [NREG*8-1:0]    regs_o
);
  localparam int unsigned PW = $clog2(NREG);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ACKA, S_SUB, S_ACKS, S_WDAT, S_ACKW, S_RDAT, S_RACK, S_IGN
  } st_t;

  st_t           st;
  logic [2:0]    scl_r, sda_r;
  logic [3:0]    cnt;
  logic [7:0]    sh, tx;
  logic [PW-1:0] ptr;
  logic          mack;
  logic [7:0]    regs [NREG];

  wire scl_hi  = scl_r[1] & scl_r[2];
  wire start_d = scl_hi & sda_r[2] & ~sda_r[1];
  wire stop_d  = scl_hi & ~sda_r[2] & sda_r[1];
  wire rise    = scl_r[1] & ~scl_r[2];
  wire fall    = ~scl_r[1] & scl_r[2];
  wire bit_in  = sda_r[1];
  wire wr_en   = fall && st == S_WDAT && cnt == 4'd8;
  wire srst    = wr_en && ptr == PW'(CTRL_IDX) && sh[0];

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      scl_r <= '1;
      sda_r <= '1;
    end else begin
      scl_r <= {scl_r[1:0], scl_i};
      sda_r <= {sda_r[1:0], sda_i};
    end

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      st     <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      tx     <= '0;
      ptr    <= '0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_d) begin
      st     <= S_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_d) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      if (rise && (st == S_ADDR || st == S_SUB || st == S_WDAT)) begin
        sh  <= {sh[6:0], bit_in};
        cnt <= cnt + 4'd1;
      end
      if (rise && st == S_RDAT) cnt <= cnt + 4'd1;
      if (rise && st == S_RACK) mack <= ~bit_in;
      if (fall) begin
        case (st)
          S_ADDR: if (cnt == 4'd8) begin
            if (sh[7:1] == DEV_ADDR) begin
              sda_oe <= 1'b1;
              st     <= S_ACKA;
            end else st <= S_IGN;
          end
          S_ACKA: if (sh[0]) begin
            tx     <= regs[ptr];
            sda_oe <= ~regs[ptr][7];
            cnt    <= '0;
            st     <= S_RDAT;
          end else begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= S_SUB;
          end
          S_SUB: if (cnt == 4'd8) begin
            ptr    <= sh[PW-1:0];
            sda_oe <= 1'b1;
            st     <= S_ACKS;
          end
          S_ACKS, S_ACKW: begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= S_WDAT;
          end
          S_WDAT: if (cnt == 4'd8) begin
            ptr    <= ptr + 1'b1;
            sda_oe <= 1'b1;
            st     <= S_ACKW;
          end
          S_RDAT: if (cnt == 4'd8) begin
            sda_oe <= 1'b0;
            ptr    <= ptr + 1'b1;
            st     <= S_RACK;
          end else begin
            tx     <= {tx[6:0], 1'b0};
            sda_oe <= ~tx[6];
          end
          S_RACK: if (mack) begin
            tx     <= regs[ptr];
            sda_oe <= ~regs[ptr][7];
            cnt    <= '0;
            st     <= S_RDAT;
          end else st <= S_IGN;
          default: ;
        endcase
      end
    end

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      for (int k = 0; k < NREG; k++) regs[k] <= 8'(k);
      soft_rst <= 1'b0;
    end else begin
      soft_rst <= srst;
      if (srst) for (int k = 0; k < NREG; k++) regs[k] <= 8'(k);
      else if (wr_en) regs[ptr] <= sh;
    end

  assign soft_pwrdn = regs[CTRL_IDX][1];

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*8 +: 8] = regs[g];
  end

  a_r2_drive_phase: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> (st == S_ACKA || st == S_ACKS || st == S_ACKW || st == S_RDAT));
  a_r7_start_restarts: assert property (@(posedge clk) disable iff (rst)
    start_d |=> (st == S_ADDR && cnt == 4'd0 && !sda_oe));
  a_r3_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (st == S_ACKW && $past(st) == S_WDAT) |-> ptr == PW'($past(ptr) + 1'b1));
  a_r8_pulse_one: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> !soft_rst);
  a_r8_defaults: assert property (@(posedge clk) disable iff (rst)
    soft_rst |-> (regs[0] == 8'd0 && regs[NREG-1] == 8'(NREG-1) && !soft_pwrdn));
endmodule

// File: tb/i2c_reg_slave_tb_top.sv
module i2c_reg_slave_tb_top;
  localparam int Q = 5;
  logic clk = 0, rst = 1;
  logic scl_m = 1, sda_m = 1;
  logic sda_oe, soft_rst, soft_pwrdn;
  logic [2047:0] regs_o;
  wire  sda = sda_m & ~sda_oe;
  int checks = 0, errors = 0, pulses = 0, rel_viol = 0;
  bit watch_rel = 0, done = 0;

  always #4 clk = ~clk;

  i2c_reg_slave dut_i (.clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda),
    .sda_oe(sda_oe), .soft_rst(soft_rst), .soft_pwrdn(soft_pwrdn), .regs_o(regs_o));

  always @(posedge clk) if (soft_rst) pulses++;
  always @(negedge clk) if (watch_rel && sda_oe) rel_viol++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask
  task automatic bstart(); sda_m = 1; qw(); scl_m = 1; qw(); sda_m = 0; qw(); scl_m = 0; qw(); endtask
  task automatic bstop(); sda_m = 0; qw(); scl_m = 1; qw(); sda_m = 1; qw(); endtask
  task automatic wbit(input logic b); sda_m = b; qw(); scl_m = 1; qw(); qw(); scl_m = 0; qw(); endtask
  task automatic rbit(output logic b); sda_m = 1; qw(); scl_m = 1; qw(); b = sda; qw(); scl_m = 0; qw(); endtask
  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = ~b;
  endtask
  task automatic rbyte(output logic [7:0] d, input logic ack);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(~ack);
  endtask
  function automatic logic [7:0] rg(int k); return regs_o[k*8 +: 8]; endfunction
  function automatic logic [7:0] pat(int k); return 8'((k * 37 + 11) & 255); endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a, a1, a2, a3;
    logic [7:0] d;
    logic b;
    int bad;
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    bad = 0;
    for (int k = 0; k < 256; k++) if (rg(k) !== 8'(k)) bad++;
    chk("R10 defaults mismatches", bad, 0);
    chk("R10 outputs", {sda_oe, soft_rst, soft_pwrdn}, 0);
    // R2/R3 write three bytes at 0x10
    bstart(); wbyte(8'h80, a); wbyte(8'h10, a1);
    chk("R1 ack on match", a, 1); chk("R2 ack sub", a1, 1);
    wbyte(8'h81, a1); wbyte(8'h3C, a2); wbyte(8'hE7, a3); bstop();
    chk("R2 data acks", {a1, a2, a3}, 3'b111);
    chk("R2 reg10", rg(16), 8'h81); chk("R3 reg11", rg(17), 8'h3C); chk("R3 reg12", rg(18), 8'hE7);
    // R4/R5 read from pointer set by earlier write
    bstart(); wbyte(8'h80, a); wbyte(8'h10, a); bstop();
    bstart(); wbyte(8'h81, a); chk("R1 read ack", a, 1);
    rbyte(d, 1); chk("R5 msb first byte0", d, 8'h81);
    rbyte(d, 1); chk("R4 byte1", d, 8'h3C);
    rbyte(d, 0); chk("R4 byte2", d, 8'hE7); bstop();
    bstart(); wbyte(8'h81, a); rbyte(d, 0); bstop();
    chk("R4 pointer persisted", d, 8'h13);
    // R1 wrong address ignored
    watch_rel = 1;
    bstart(); wbyte(8'h82, a); wbyte(8'h20, a1); wbyte(8'h55, a2); bstop();
    watch_rel = 0;
    chk("R1 nack on mismatch", {a, a1, a2}, 0);
    chk("R1 sda released", rel_viol, 0);
    chk("R1 no write", rg(32), 8'h20);
    // R6 master NACK releases SDA
    bstart(); wbyte(8'h80, a); wbyte(8'h10, a); bstop();
    bstart(); wbyte(8'h81, a); rbyte(d, 0);
    watch_rel = 1;
    for (int i = 0; i < 9; i++) rbit(b);
    bstop();
    watch_rel = 0;
    chk("R6 read before nack", d, 8'h81);
    chk("R6 released after nack", rel_viol, 0);
    // R7 START inside a byte
    bstart(); wbit(1); wbit(0); wbit(1); wbit(0);
    bstart(); wbyte(8'h80, a); wbyte(8'h30, a1); wbyte(8'h99, a2); bstop();
    chk("R7 acks after restart", {a, a1, a2}, 3'b111);
    chk("R7 write after restart", rg(48), 8'h99);
    // R3 wrap and R9 power-down
    bstart(); wbyte(8'h80, a); wbyte(8'hFE, a); wbyte(8'h12, a); wbyte(8'h34, a); wbyte(8'h02, a); bstop();
    chk("R3 regFE", rg(254), 8'h12); chk("R3 regFF", rg(255), 8'h34); chk("R3 wrap reg00", rg(0), 8'h02);
    chk("R9 pwrdn set", soft_pwrdn, 1); chk("R9 regs kept", rg(16), 8'h81);
    // R8 soft reset
    bstart(); wbyte(8'h80, a); wbyte(8'h00, a); wbyte(8'h03, a); bstop();
    chk("R8 one pulse", pulses, 1);
    chk("R8 pwrdn cleared", soft_pwrdn, 0);
    bad = 0;
    for (int k = 0; k < 256; k++) if (rg(k) !== 8'(k)) bad++;
    chk("R8 defaults mismatches", bad, 0);
    bstart(); wbyte(8'h81, a); rbyte(d, 0); bstop();
    chk("R8 pointer advanced", d, 8'h01);
    // sweep: write 0x01..0xFF in one burst, read back in one burst
    bstart(); wbyte(8'h80, a); wbyte(8'h01, a);
    for (int k = 1; k < 256; k++) wbyte(pat(k), a);
    bstop();
    bad = 0;
    for (int k = 1; k < 256; k++) if (rg(k) !== pat(k)) bad++;
    chk("R2 sweep write mismatches", bad, 0);
    bstart(); wbyte(8'h80, a); wbyte(8'h01, a); bstop();
    bstart(); wbyte(8'h81, a);
    bad = 0;
    for (int k = 1; k < 256; k++) begin
      rbyte(d, k != 255);
      if (d !== pat(k)) bad++;
    end
    bstop();
    chk("R4 sweep read mismatches", bad, 0);
    chk("R8 no stray pulse", pulses, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule